// File: doc/BRIEF.md
# Half-Duplex Serial Bus Slave Endpoint

This block is the slave end of a synchronous, half-duplex bus. The bus has an active-low select, a clock driven by the master, eight shared data lines and one status line that only the slave drives. The whole block runs on the bus clock. On the first rising edge after select goes low, the block samples all eight data lines. From which lines are pulled low it works out the requested bus width, by priority. It then collects a 4-bit command and, after one turnaround clock, moves bytes one bit per clock on data line 0, most significant bit first. Bytes keep coming for as long as select stays low. For every byte the status line carries an acknowledge (0) or a refusal (1).

Between transactions the same two slave outputs report buffer state, if `status_en` is high. Line 0 reports whether the receive buffer is full, and the status line reports whether the transmit buffer is empty. With `status_en` low, both outputs are released, so several slaves can share the wires. Bytes written by the master leave through a valid/ready stream (`rx_*`). Bytes for the master enter through a second valid/ready stream (`tx_*`). Both pass through small internal FIFOs. A producer may only consider a byte taken on a clock where valid and ready are both high. A consumer may hold `rx_ready` low for as long as it likes: the byte and `rx_valid` stay put, and the master then gets refusals once the receive FIFO is full. Data phases wider than one bit are not carried out. Their width and command are still decoded and reported, and every byte is refused.

Top module: `hdx_slave`

## Requirements
- R1: On the first rising edge with `sel_n` low, `width_o` takes the decoded width. The code is 3 (8 bits) if any of `bus_i[7:4]` is 0. Otherwise it is 2 (4 bits) if any of `bus_i[3:2]` is 0. Otherwise it is 1 (2 bits) if `bus_i[1]` is 0. Otherwise it is 0 (1 bit). A line left at 1 never selects a wider width.
- R2: When the width is not 1 bit, `cmd_o` after the first edge is {bus_i[0], bus_i[3], bus_i[5], bus_i[6]}, ordered cmd bit 3 down to 0. In 1-bit mode the command arrives serially on `bus_i[0]` over edges 0..6. Edge 0 carries cmd bit 3, edge 3 bit 2, edge 5 bit 1 and edge 6 bit 0. Edges 1, 2 and 4 are ignored, and edge 7 is turnaround.
- R3: While `sel_n` is high and `status_en` is 1, `bus0_oe` and `stat_oe` are 1. `bus0_o` is 1 exactly when the receive FIFO is full, and `stat_o` is 1 exactly when the transmit FIFO is empty. With `status_en` 0, both enables are 0.
- R4: While `sel_n` is low, `stat_oe` is 1. `bus0_oe` is 0 at once (no clock needed) from the moment select falls, and stays 0 except in the data phase of a read (command 1).
- R5: Command 0 (write) samples `bus_i[0]` on the 8 edges of each data byte, MSB first. An acknowledged byte is pushed into the receive FIFO. Bytes follow back to back while select stays low.
- R6: Command 1 (read) pops the transmit FIFO at the turnaround edge and at the last edge of each byte. It drives the popped byte MSB first on `bus0_o`. Each bit is valid from the edge before the edge that samples it.
- R7: After the turnaround edge and after each byte's last edge, `stat_o` shows 0 (ACK) or 1 (NAK) for the coming byte and holds it for all 8 clocks of that byte.
- R8: A byte is refused (NAK) when the receive FIFO has no room on a write, when the transmit FIFO is empty on a read, for any command other than 0 or 1, and for any width other than 1 bit. A refused byte neither pushes nor pops a FIFO.
- R9: `rx_valid` with `rx_data` holds until taken with `rx_ready`, in arrival order. `tx_ready` is 0 exactly when the transmit FIFO holds DEPTH bytes.
- R10: Raising `sel_n` ends the transaction at once. The next low period of `sel_n` starts a fresh command phase, and at least one clock edge must fall in the high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the master |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low slave select |
| status_en | input | 1 | Drive buffer status while not selected |
| bus_i | input | 8 | Sampled value of the shared data lines |
| bus0_o | output | 1 | Value driven on data line 0 |
| bus0_oe | output | 1 | Output enable for data line 0 |
| stat_o | output | 1 | Value on the status line |
| stat_oe | output | 1 | Output enable for the status line |
| width_o | output | 2 | Decoded width code of the current or last transaction |
| cmd_o | output | 4 | Command of the current or last transaction |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Producer offers a byte for the master |
| tx_ready | output | 1 | Transmit FIFO has room |
| tx_data | input | 8 | Byte for the master |

## Verification
The hardest case to reach from the ports is a refusal that lands inside one select window. The byte before it was acknowledged, and only that byte's own push fills the receive FIFO, so the next byte sees no room. The stimulus gets there by holding `rx_ready` low and writing one byte more than the FIFO depth in a single transaction. A read transaction does the same on the transmit side by asking for one byte more than was queued. The width decoder is swept over all 256 first-edge words, each followed by a deselect.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [1:0] {
    WID_1 = 2'd0,
    WID_2 = 2'd1,
    WID_4 = 2'd2,
    WID_8 = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [3:0] OP_WRITE = 4'h0;
  localparam logic [3:0] OP_READ  = 4'h1;
endpackage

// File: rtl/hdx_fifo.sv
module hdx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/hdx_width_dec.sv
module hdx_width_dec
  import hdx_pkg::*;
(
  input  logic [7:0] word,
  output width_e     width,
  output logic [3:0] cmd_wide
);
  always_comb begin
    if (!(&word[7:4]))      width = WID_8;
    else if (!(&word[3:2])) width = WID_4;
    else if (!word[1])      width = WID_2;
    else                    width = WID_1;
  end

  assign cmd_wide = {word[0], word[3], word[5], word[6]};
endmodule

// File: rtl/hdx_engine.sv
module hdx_engine
  import hdx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          status_en,
  input  logic [7:0]    bus_i,
  output logic          bus0_o,
  output logic          bus0_oe,
  output logic          stat_o,
  output logic          stat_oe,
  output logic [1:0]    width_o,
  output logic [3:0]    cmd_o,
  output logic          rx_push,
  output logic [7:0]    rx_push_data,
  input  logic [CW-1:0] rx_level,
  input  logic          rx_pop,
  output logic          tx_pop,
  input  logic [7:0]    tx_head,
  input  logic [CW-1:0] tx_level
);
  phase_e     phase;
  logic [2:0] cnt;
  width_e     width_q;
  logic [3:0] cmd_q;
  logic       nak_q;
  logic [7:0] shreg;

  width_e     dec_width;
  logic [3:0] dec_cmd;

  hdx_width_dec u_dec (
    .word     (bus_i),
    .width    (dec_width),
    .cmd_wide (dec_cmd)
  );

  logic is_rd, is_wr, narrow, boundary, rx_space, tx_avail, next_ok;

  assign is_rd    = (cmd_q == OP_READ);
  assign is_wr    = (cmd_q == OP_WRITE);
  assign narrow   = (width_q == WID_1);
  assign boundary = !sel_n && (cnt == 3'd7) &&
                    ((phase == PH_CMD) || (phase == PH_DATA));
  assign rx_space = (int'(rx_level) + int'(rx_push) - int'(rx_pop)) < DEPTH;
  assign tx_avail = (tx_level != '0);
  assign next_ok  = narrow && ((is_wr && rx_space) || (is_rd && tx_avail));

  assign rx_push      = !sel_n && (phase == PH_DATA) && (cnt == 3'd7) &&
                        is_wr && !nak_q;
  assign rx_push_data = {shreg[6:0], bus_i[0]};
  assign tx_pop       = boundary && narrow && is_rd && tx_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      width_q <= WID_1;
      cmd_q   <= '0;
      nak_q   <= 1'b1;
      shreg   <= '0;
    end else if (sel_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          width_q <= dec_width;
          cmd_q   <= (dec_width == WID_1) ? {bus_i[0], 3'b000} : dec_cmd;
          phase   <= PH_CMD;
          cnt     <= 3'd1;
        end
        PH_CMD: begin
          cnt <= cnt + 1'b1;
          if (narrow) begin
            case (cnt)
              3'd3:    cmd_q[2] <= bus_i[0];
              3'd5:    cmd_q[1] <= bus_i[0];
              3'd6:    cmd_q[0] <= bus_i[0];
              default: ;
            endcase
          end
          if (cnt == 3'd7) begin
            phase <= PH_DATA;
            nak_q <= !next_ok;
            if (tx_pop) shreg <= tx_head;
          end
        end
        PH_DATA: begin
          cnt   <= cnt + 1'b1;
          shreg <= {shreg[6:0], is_wr ? bus_i[0] : 1'b0};
          if (cnt == 3'd7) begin
            nak_q <= !next_ok;
            if (tx_pop) shreg <= tx_head;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign bus0_oe = sel_n ? status_en : ((phase == PH_DATA) && is_rd);
  assign bus0_o  = sel_n ? (rx_level == CW'(DEPTH)) : shreg[7];
  assign stat_oe = sel_n ? status_en : 1'b1;
  assign stat_o  = (!sel_n && phase == PH_DATA) ? nak_q : (tx_level == '0);
  assign width_o = width_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/hdx_slave.sv
module hdx_slave #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       status_en,
  input  logic [7:0] bus_i,
  output logic       bus0_o,
  output logic       bus0_oe,
  output logic       stat_o,
  output logic       stat_oe,
  output logic [1:0] width_o,
  output logic [3:0] cmd_o,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]    rx_push_data;
  logic [CW-1:0] rx_level;
  logic          tx_pop, tx_full, tx_empty;
  logic [7:0]    tx_head;
  logic [CW-1:0] tx_level;

  assign rx_valid = !rx_empty;
  assign rx_pop   = rx_valid && rx_ready;
  assign tx_ready = !tx_full;

  hdx_fifo #(.W(8), .DEPTH(DEPTH)) u_rx (
    .clk, .rst_n,
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_pop),
    .head      (rx_data),
    .level     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  hdx_fifo #(.W(8), .DEPTH(DEPTH)) u_tx (
    .clk, .rst_n,
    .push      (tx_valid && tx_ready),
    .push_data (tx_data),
    .pop       (tx_pop),
    .head      (tx_head),
    .level     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  hdx_engine #(.DEPTH(DEPTH)) u_eng (
    .clk, .rst_n, .sel_n, .status_en, .bus_i,
    .bus0_o, .bus0_oe, .stat_o, .stat_oe, .width_o, .cmd_o,
    .rx_push, .rx_push_data, .rx_level, .rx_pop,
    .tx_pop, .tx_head, .tx_level
  );
endmodule

// File: rtl/hdx_slave_chk.sv
module hdx_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       status_en,
  input logic       bus0_oe,
  input logic       stat_oe,
  input logic       rx_push,
  input logic       rx_full,
  input logic       tx_pop,
  input logic       tx_empty,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !status_en) |-> (!bus0_oe && !stat_oe)); // R3
  AST_SEL_STAT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> stat_oe); // R4
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !bus0_oe); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9
endmodule

bind hdx_slave hdx_slave_chk u_chk (
  .clk, .rst_n, .sel_n, .status_en, .bus0_oe, .stat_oe,
  .rx_push, .rx_full, .tx_pop, .tx_empty,
  .rx_valid, .rx_ready, .rx_data
);

// File: tb/hdx_slave_tb_top.sv
module hdx_slave_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n, sel_n, status_en, rx_ready, tx_valid;
  logic [7:0] bus_i, tx_data;
  logic bus0_o, bus0_oe, stat_o, stat_oe, rx_valid, tx_ready;
  logic [1:0] width_o;
  logic [3:0] cmd_o;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] wdat [8];
  logic [7:0] rexp [8];
  logic       nexp [8];

  always #5 clk = ~clk;

  hdx_slave #(.DEPTH(DEPTH)) dut_i (
    .clk, .rst_n, .sel_n, .status_en, .bus_i,
    .bus0_o, .bus0_oe, .stat_o, .stat_oe, .width_o, .cmd_o,
    .rx_valid, .rx_ready, .rx_data, .tx_valid, .tx_ready, .tx_data
  );

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wexp(input logic [7:0] v);
    if (!(&v[7:4])) return 3;
    if (!(&v[3:2])) return 2;
    if (!v[1]) return 1;
    return 0;
  endfunction

  // One 1-bit-mode transaction: nb bytes, using wdat/rexp/nexp
  task automatic txn(input logic [3:0] cmd, input int nb);
    sel_n = 1'b0;
    bus_i = {7'h7F, cmd[3]};
    #1 chk("R4 released at select", bus0_oe, 0);
    edge1();
    for (int k = 1; k < 7; k++) begin
      bus_i[0] = (k == 3) ? cmd[2] : (k == 5) ? cmd[1] : (k == 6) ? cmd[0] : 1'b0;
      chk("R4 command phase no drive", bus0_oe, 0);
      edge1();
    end
    bus_i = 8'hFF;
    edge1();
    chk("R2 serial command", cmd_o, cmd);
    for (int b = 0; b < nb; b++) begin
      chk("R7 ack at byte start", stat_o, nexp[b]);
      for (int i = 0; i < 8; i++) begin
        if (cmd == 4'h0) bus_i[0] = wdat[b][7-i];
        if (cmd == 4'h1) begin
          chk("R6 read drive enable", bus0_oe, 1);
          if (!nexp[b]) chk("R6 read bit", bus0_o, rexp[b][7-i]);
        end else begin
          chk("R4 no drive outside read", bus0_oe, 0);
        end
        if (i == 7) chk("R7 ack held", stat_o, nexp[b]);
        edge1();
      end
    end
    bus_i = 8'hFF;
    sel_n = 1'b1;
    #1 chk("R10 deselect restores status drive", bus0_oe, status_en);
    edge1();
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; status_en = 1'b1; rx_ready = 1'b0;
    tx_valid = 1'b0; tx_data = '0; bus_i = 8'hFF;
    repeat (3) edge1();
    rst_n = 1'b1;
    edge1();

    // Reset / idle state
    chk("R3 idle bus0_oe", bus0_oe, 1);
    chk("R3 idle rx not full", bus0_o, 0);
    chk("R3 idle stat_oe", stat_oe, 1);
    chk("R3 idle tx empty", stat_o, 1);
    chk("R9 rx_valid at reset", rx_valid, 0);
    chk("R9 tx_ready at reset", tx_ready, 1);

    // R3: status disabled releases both lines
    status_en = 1'b0;
    #1 chk("R3 disabled bus0_oe", bus0_oe, 0);
    chk("R3 disabled stat_oe", stat_oe, 0);
    status_en = 1'b1;
    edge1();

    // R1/R2: exhaustive first-edge sweep
    for (int v = 0; v < 256; v++) begin
      sel_n = 1'b0;
      bus_i = 8'(v);
      edge1();
      chk("R1 width decode", width_o, wexp(8'(v)));
      if (wexp(8'(v)) != 0)
        chk("R2 wide command", cmd_o, {bus_i[0], bus_i[3], bus_i[5], bus_i[6]});
      else
        chk("R2 first serial bit", cmd_o, {bus_i[0], 3'b000});
      chk("R4 stat driven while selected", stat_oe, 1);
      sel_n = 1'b1;
      bus_i = 8'hFF;
      edge1();
    end

    // R5/R8: write DEPTH+1 bytes with consumer stalled
    for (int b = 0; b < 5; b++) begin
      wdat[b] = 8'(8'h3C + 8'(b * 37));
      nexp[b] = (b >= DEPTH);
    end
    txn(4'h0, 5);
    chk("R3 idle rx full", bus0_o, 1);
    chk("R9 rx_valid after write", rx_valid, 1);
    edge1();
    edge1();
    chk("R9 rx_data held under stall", rx_data, wdat[0]);
    for (int b = 0; b < DEPTH; b++) begin
      chk("R5 rx order valid", rx_valid, 1);
      chk("R5 rx byte", rx_data, wdat[b]);
      rx_ready = 1'b1;
      edge1();
      rx_ready = 1'b0;
    end
    chk("R8 refused byte not pushed", rx_valid, 0);
    chk("R3 idle rx not full after drain", bus0_o, 0);

    // R8: read with empty transmit FIFO
    nexp[0] = 1'b1;
    txn(4'h1, 1);

    // R6/R9: fill transmit FIFO, read DEPTH+1 bytes
    for (int b = 0; b < DEPTH; b++) begin
      rexp[b] = 8'(8'h81 ^ 8'(b * 53));
      tx_valid = 1'b1;
      tx_data = rexp[b];
      edge1();
    end
    tx_valid = 1'b0;
    chk("R9 tx_ready low when full", tx_ready, 0);
    chk("R3 idle tx not empty", stat_o, 0);
    for (int b = 0; b < 5; b++) nexp[b] = (b >= DEPTH);
    txn(4'h1, 5);
    chk("R9 tx_ready after drain", tx_ready, 1);
    chk("R3 idle tx empty after read", stat_o, 1);

    // R8: unknown commands refuse and touch no FIFO
    tx_valid = 1'b1;
    tx_data = 8'hE7;
    edge1();
    tx_valid = 1'b0;
    for (int c = 2; c < 16; c++) begin
      nexp[0] = 1'b1;
      wdat[0] = 8'hA5;
      txn(4'(c), 1);
      chk("R8 unknown cmd no push", rx_valid, 0);
      chk("R8 unknown cmd no pop", stat_o, 0);
    end

    // R8: 8-bit width with read command refuses
    sel_n = 1'b0;
    bus_i = 8'hC6;
    edge1();
    chk("R1 wide read width", width_o, 3);
    chk("R2 wide read command", cmd_o, 1);
    bus_i = 8'hFF;
    repeat (7) edge1();
    chk("R8 wide width NAK", stat_o, 1);
    repeat (8) edge1();
    sel_n = 1'b1;
    edge1();
    chk("R8 wide width no pop", stat_o, 0);

    // R6: byte still there, read it in 1-bit mode
    nexp[0] = 1'b0;
    rexp[0] = 8'hE7;
    txn(4'h1, 1);
    chk("R6 transmit FIFO empty after read", stat_o, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule